// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM organised as 16-bit words with a 6-bit word address. It drives chip select, shift clock and serial data toward the memory and samples the memory's serial data output. A host presents an address and a one-cycle start pulse. The block shifts out a read command and clocks in the 16 data bits. It then returns the word together with a completion strobe.

A second mode is selected with start. In this mode the block ignores the host address and walks the 12-word configuration area from word 0 upward, back to back. It raises a per-word strobe and the word's address as each word arrives. The shift clock rate comes from a run-time half-period setting expressed in system clock cycles. The setting allows the block to meet slow memory timing from a fast system clock.

Top module: `ee3w_reader`

## Requirements
- R1: An access sends an 11-bit command, most significant bit first, on rising shift clock edges: two zero bits, then the read opcode bits 1,1,0, then the six address bits, MSB first.
- R2: Chip select rises while shift clock and serial data are both low, and the first shift clock rise follows two half periods later.
- R3: Each command bit is placed on serial data while the shift clock is low, and serial data does not change while the shift clock is high.
- R4: After the command, serial data stays low with chip select high for 16 shift clock pulses. Memory output is sampled at the end of each high half. The first sample becomes data bit 0 and the sixteenth becomes bit 15.
- R5: At the end, shift clock and serial data are low for two half periods before chip select falls, and chip select stays low for one half period before completion.
- R6: One half period lasts `half_i` system cycles, with 0 treated as 1. A single read ends with `done_o` high after 58·H+1 rising edges following the edge that samples start.
- R7: `done_o` is a one-cycle pulse, and `data_o` keeps the returned word after completion until another access starts.
- R8: `busy_o` is high from the edge after start through the cycle in which `done_o` is high, and low in the following cycle. A start pulse while busy is high begins no access and changes neither the address nor the result.
- R9: With `seq_i` high at start, words 0 to 11 are read in ascending order whatever `addr_i` holds. `word_valid_o` pulses once per word with `word_addr_o` and `data_o` valid. `done_o` follows the twelfth word.
- R10: In single mode `word_valid_o` pulses one cycle before `done_o`, with `word_addr_o` equal to the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an access |
| seq_i | input | 1 | Sampled with start: 1 walks the configuration area |
| addr_i | input | 6 | Word address for a single read |
| half_i | input | 8 | Shift clock half period in system cycles (0 acts as 1) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_valid_o | output | 1 | One-cycle pulse for each word returned |
| word_addr_o | output | 6 | Address of the word being returned |
| data_o | output | 16 | Returned word |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sk_o | output | 1 | Memory shift clock |
| ee_di_o | output | 1 | Serial data toward the memory |
| ee_do_i | input | 1 | Serial data from the memory |

## Verification
The assertions check the following on every cycle:
- the shift clock appears only under chip select;
- serial data holds across every rising shift clock edge;
- chip select rises and falls only with clock and data low;
- completion is a single pulse, and busy drops right after it;
- sequential addresses stay in range and advance by one.

The bench scenarios show what no single-cycle property can see:
- the command bit pattern and the bit order of the assembled word;
- the exact access length for several half-period settings;
- the two-half-period spacing around chip select;
- that a start pulse during an access leaves the result untouched.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int PAD_BITS = 2;
    localparam logic [2:0] OP_READ = 3'b110;
    localparam int CMD_BITS = PAD_BITS + 3 + ADDR_W;
    // half-period step map of one access
    localparam int ST_CMD0  = 1;
    localparam int ST_GAP   = ST_CMD0 + 2 * CMD_BITS;
    localparam int ST_RD0   = ST_GAP + 1;
    localparam int ST_END   = ST_RD0 + 2 * DATA_W;
    localparam int ST_DESEL = ST_END + 1;
    localparam int STEPS    = ST_DESEL + 1;
    localparam int STEP_W   = $clog2(STEPS);
endpackage

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = (half_i == '0) ? DIV_W'(1) : half_i;
        tick_o = en_i && (cnt_q >= lim - DIV_W'(1));
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: with a half period above one cycle, ticks never come back to back
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && half_i > DIV_W'(1)) |=> (!tick_o || half_i <= DIV_W'(1)));
endmodule

// File: rtl/ee3w_engine.sv
module ee3w_engine
    import ee3w_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DIV_W-1:0]  half_i,
    input  logic              ee_do_i,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic                active;
        logic                done;
        logic [STEP_W-1:0]   step;
        logic [CMD_BITS-1:0] frame;
        logic [DATA_W-1:0]   shift;
    } eng_t;

    eng_t r_q, r_d;
    logic tick, in_cmd, in_rd, sk_hi;

    ee3w_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.active),
        .half_i (half_i),
        .tick_o (tick)
    );

    always_comb begin
        in_cmd = r_q.active && (r_q.step >= STEP_W'(ST_CMD0)) && (r_q.step < STEP_W'(ST_GAP));
        in_rd  = r_q.active && (r_q.step >= STEP_W'(ST_RD0))  && (r_q.step < STEP_W'(ST_END));
        // command bits: low half first; read bits: high half first
        sk_hi  = (in_cmd && (r_q.step[0] != 1'(ST_CMD0 % 2)))
              || (in_rd  && (r_q.step[0] == 1'(ST_RD0 % 2)));

        ee_cs_o = r_q.active && (r_q.step != STEP_W'(ST_DESEL));
        ee_sk_o = sk_hi;
        ee_di_o = in_cmd && r_q.frame[CMD_BITS-1];
        done_o  = r_q.done;
        data_o  = r_q.shift;

        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            if (go_i) begin
                r_d.active = 1'b1;
                r_d.step   = '0;
                // R1: zero padding, read opcode, address
                r_d.frame  = {{PAD_BITS{1'b0}}, OP_READ, addr_i};
            end
        end else if (tick) begin
            if (in_cmd && sk_hi) r_d.frame = {r_q.frame[CMD_BITS-2:0], 1'b0};
            // R4: first sample lands in bit 0 after sixteen right shifts
            if (in_rd && sk_hi)  r_d.shift = {ee_do_i, r_q.shift[DATA_W-1:1]};
            if (r_q.step == STEP_W'(ST_DESEL)) begin
                r_d.active = 1'b0;
                r_d.done   = 1'b1;
                r_d.step   = '0;
            end else begin
                r_d.step = r_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    a_r4_clock_under_select: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk_o |-> ee_cs_o);
    a_r3_data_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk_o) |-> $stable(ee_di_o));
    a_r2_select_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs_o) |-> (!ee_sk_o && !ee_di_o));
    a_r5_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs_o) |-> (!ee_sk_o && !ee_di_o && !$past(ee_sk_o) && !$past(ee_di_o)));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/ee3w_reader.sv
module ee3w_reader
    import ee3w_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int CFG_WORDS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              seq_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DIV_W-1:0]  half_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              word_valid_o,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    input  logic              ee_do_i
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CFG_WORDS - 1);

    typedef struct packed {
        logic              run;
        logic              seq;
        logic              done;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t s_q, s_d;
    logic eng_go, eng_done;
    logic [ADDR_W-1:0] eng_addr;

    ee3w_engine #(.DIV_W(DIV_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (eng_go),
        .addr_i  (eng_addr),
        .half_i  (half_i),
        .ee_do_i (ee_do_i),
        .ee_cs_o (ee_cs_o),
        .ee_sk_o (ee_sk_o),
        .ee_di_o (ee_di_o),
        .done_o  (eng_done),
        .data_o  (data_o)
    );

    always_comb begin
        busy_o       = s_q.run | s_q.done;
        done_o       = s_q.done;
        word_valid_o = eng_done;
        word_addr_o  = s_q.addr;

        s_d      = s_q;
        s_d.done = 1'b0;
        eng_go   = 1'b0;
        eng_addr = s_q.addr;
        if (!busy_o && start_i) begin
            s_d.run  = 1'b1;
            s_d.seq  = seq_i;
            s_d.addr = seq_i ? '0 : addr_i;
            eng_go   = 1'b1;
            eng_addr = s_d.addr;
        end else if (s_q.run && eng_done) begin
            if (s_q.seq && (s_q.addr != LAST_ADDR)) begin
                s_d.addr = s_q.addr + ADDR_W'(1);
                eng_go   = 1'b1;
                eng_addr = s_d.addr;
            end else begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !word_valid_o) |=> $stable(word_addr_o));
    a_r9_seq_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && s_q.seq) |-> (word_addr_o <= LAST_ADDR));
    a_r9_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && s_q.seq && word_addr_o != LAST_ADDR)
        |=> (word_addr_o == $past(word_addr_o) + ADDR_W'(1)));
    a_r10_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(word_valid_o));
endmodule

// File: tb/tb_ee3w_reader.sv
`timescale 1ns/1ps
module tb_ee3w_reader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       seq = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] half = 8'd1;
    logic       busy, done, wvalid, ee_cs, ee_sk, ee_di;
    logic       ee_do = 1'b0;
    logic [5:0] waddr;
    logic [15:0] data;

    ee3w_reader #(.DIV_W(8), .CFG_WORDS(12)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .seq_i(seq), .addr_i(addr),
        .half_i(half), .busy_o(busy), .done_o(done), .word_valid_o(wvalid),
        .word_addr_o(waddr), .data_o(data), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk),
        .ee_di_o(ee_di), .ee_do_i(ee_do)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [15:0] mem_word(input logic [5:0] a);
        return 16'h9E37 ^ {a, a[3:0], a};
    endfunction

    // memory model
    int bitcnt = 0, rdcnt = 0, cs_rises = 0, di_moves = 0, rd_di_high = 0;
    int sel_bad = 0, rel_bad = 0;
    logic [10:0] frame_seen = '0;
    logic [5:0]  m_addr = '0;
    logic [15:0] m_word;
    realtime t_cs_rise = 0, t_sk_fall = 0, sel_gap = 0, rel_gap = 0;

    always @(posedge ee_cs) begin
        bitcnt = 0; rdcnt = 0; cs_rises++; t_cs_rise = $realtime;
        if (ee_sk || ee_di) sel_bad++;
    end
    always @(posedge ee_sk) if (ee_cs) begin
        if (bitcnt == 0) sel_gap = $realtime - t_cs_rise;
        if (bitcnt < 11) begin
            frame_seen = {frame_seen[9:0], ee_di};
            bitcnt++;
            if (bitcnt == 11) m_addr = frame_seen[5:0];
        end else begin
            if (ee_di) rd_di_high++;
            m_word = mem_word(m_addr);
            if (rdcnt < 16) ee_do = m_word[rdcnt];
            rdcnt++;
        end
    end
    always @(negedge ee_sk) t_sk_fall = $realtime;
    always @(negedge ee_cs) begin
        rel_gap = $realtime - t_sk_fall;
        if (ee_sk || ee_di) rel_bad++;
    end
    always @(ee_di) if (ee_sk && ee_cs) di_moves++;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8", "busy in reset", busy, 0);
        check("R2", "cs in reset", ee_cs, 0);
        check("R7", "done in reset", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "busy after reset", busy, 0);
        check("R4", "clock idle", ee_sk, 0);
        check("R10", "word strobe idle", wvalid, 0);
    endtask

    task automatic t_single(input logic [5:0] a, input logic [7:0] h);
        int n, wv_at, eff, r0;
        logic [5:0] wa;
        eff = (h == 0) ? 1 : int'(h);
        wv_at = -1; wa = '0;
        @(negedge clk);
        half = h; addr = a; seq = 1'b0; start = 1'b1;
        r0 = cs_rises; di_moves = 0; rd_di_high = 0; sel_bad = 0; rel_bad = 0;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (wvalid && wv_at < 0) begin wv_at = n; wa = waddr; end
        end while (!done && n < 20000);
        check("R6", "cycles to done", n, 58 * eff + 1);
        check("R10", "word strobe cycle", wv_at, 58 * eff);
        check("R10", "word address", wa, a);
        check("R1", "command frame", frame_seen, {2'b00, 3'b110, a});
        check("R4", "returned word", data, mem_word(a));
        check("R4", "data line during read", rd_di_high, 0);
        check("R3", "data moved with clock high", di_moves, 0);
        check("R2", "select quiet", sel_bad, 0);
        check("R2", "select to first rise ns", longint'(sel_gap), 16 * eff);
        check("R5", "last fall to release ns", longint'(rel_gap), 16 * eff);
        check("R5", "release quiet", rel_bad, 0);
        check("R8", "busy in done cycle", busy, 1);
        check("R8", "one access", cs_rises - r0, 1);
        @(negedge clk);
        check("R7", "done pulse width", done, 0);
        check("R8", "busy after done", busy, 0);
        repeat (10) @(negedge clk);
        check("R7", "word held", data, mem_word(a));
    endtask

    task automatic t_busy_ignore(input logic [5:0] a, input logic [5:0] b);
        int n, r0;
        @(negedge clk);
        half = 8'd2; addr = a; seq = 1'b0; start = 1'b1; r0 = cs_rises;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check("R8", "busy mid access", busy, 1);
        addr = b; seq = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        check("R8", "ignored start: accesses", cs_rises - r0, 1);
        check("R8", "ignored start: word", data, mem_word(a));
        check("R8", "ignored start: address", waddr, a);
        @(negedge clk);
    endtask

    task automatic t_seq(input logic [7:0] h);
        int n, idx, r0;
        @(negedge clk);
        half = h; addr = 6'd45; seq = 1'b1; start = 1'b1; r0 = cs_rises;
        @(negedge clk);
        start = 1'b0; seq = 1'b0;
        idx = 0; n = 0;
        while (!done && n < 50000) begin
            @(negedge clk);
            n++;
            if (wvalid) begin
                check("R9", "sequential address", waddr, idx);
                check("R9", "sequential word", data, mem_word(6'(idx)));
                idx++;
            end
        end
        check("R9", "word count", idx, 12);
        check("R9", "access count", cs_rises - r0, 12);
        check("R9", "done seen", done, 1);
        @(negedge clk);
        check("R8", "busy after sequence", busy, 0);
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_single(6'h2A, 8'd1);
        t_single(6'h15, 8'd3);
        t_single(6'h3F, 8'd0);
        t_single(6'h00, 8'd2);
        t_busy_ignore(6'h07, 6'h31);
        t_seq(8'd1);
        t_seq(8'd2);
        summary();
        $finish;
    end
endmodule